// File: doc/BRIEF.md
# Elevator Car Motion and Door Controller

This block steers a single elevator car toward one target floor. Each clock it compares the car's present floor with an already resolved target floor. It commands the car up or down until the two agree, and then keeps the door open for a dwell measured in one-second ticks. Between trips it rests with the door open. A fire alarm input takes priority over all normal behaviour. The car is sent down to the home floor and the door is opened there. The controller returns to normal service only after the fire sequence has reached the home floor and the alarm has cleared.

All commands are Moore outputs decoded from the registered state. The one exception is the descent command during the fire sequence, which is also gated by the floor comparison so that the car stops as soon as it reaches the home floor. Floor width, home floor and dwell length are parameters.

Top module: `elev_unit_ctrl`

## Requirements
- R1: After reset the controller rests with `door_open_o`=1 and `move_up_o`, `move_dn_o` and `dwell_run_o` all 0.
- R2: While resting, one clock after `target_i` > `floor_i` the outputs become up=1 with door closed. One clock after `target_i` < `floor_i` they become down=1 with door closed. With `target_i` == `floor_i` the controller keeps resting.
- R3: While ascending, the car keeps moving up as long as `target_i` > `floor_i`. While descending, it keeps moving down as long as `target_i` < `floor_i`. One clock after the condition fails, it enters the dwell state, which drives `door_open_o`=1 and `dwell_run_o`=1.
- R4: During the dwell, a counter starts at zero on entry and counts cycles with `tick_i`=1. It saturates at DWELL_TICKS (default 10). The controller returns to rest one clock after the cycle in which the DWELL_TICKS-th tick is sampled. Ticks seen outside the dwell have no effect on its length.
- R5: `door_open_o` is 0 whenever `move_up_o` or `move_dn_o` is 1, and the two move outputs are never 1 together.
- R6: With `fire_i`=1 in any normal state, the next state is the fire descent. This takes priority over every normal transition due in the same cycle.
- R7: In fire descent, `door_open_o`=0 and `move_dn_o` = (`floor_i` > HOME_FLOOR, default 1). One clock after `floor_i` <= HOME_FLOOR the controller holds the door open at home, with all move outputs 0.
- R8: Fire mode is left, to the resting state, only from the door-open-at-home state and only one clock after `fire_i`=0 is sampled. Clearing `fire_i` during the descent does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| floor_i | input | FLOOR_W | Present floor of the car, unsigned |
| target_i | input | FLOOR_W | Resolved target floor, unsigned |
| fire_i | input | 1 | Fire alarm |
| tick_i | input | 1 | One-cycle pulse each second |
| move_up_o | output | 1 | Drive car upward |
| move_dn_o | output | 1 | Drive car downward |
| door_open_o | output | 1 | Door open command |
| dwell_run_o | output | 1 | Dwell timer running |

## Verification
Two pairs of events can fall due in the same cycle, and each is set up on purpose. In the first, the alarm rises in the same cycle that the dwell counter reaches its limit. In the second, the alarm rises in the same cycle that an ascending car reaches its target. The bench sets up both conditions before a single clock edge and then requires the fire descent pattern on the outputs, with neither the rest pattern nor the dwell pattern appearing. A third case clears the alarm partway through the descent. It checks that the descent continues and that the rest pattern appears only after the door has opened at home.

// File: rtl/elev_pkg.sv
package elev_pkg;

   typedef enum logic [2:0] {
      ST_REST   = 3'd0,
      ST_ASCEND = 3'd1,
      ST_DESCND = 3'd2,
      ST_DWELL  = 3'd3,
      ST_FIRE_DN = 3'd4,
      ST_FIRE_OPEN = 3'd5
   } car_state_e;

   typedef struct packed {
      logic up;
      logic dn;
      logic open;
      logic run;
   } car_cmd_t;

   function automatic logic is_fire_state(car_state_e s);
      return (s == ST_FIRE_DN) || (s == ST_FIRE_OPEN);
   endfunction

endpackage

// File: rtl/elev_floor_cmp.sv
module elev_floor_cmp #(
   parameter int FLOOR_W    = 4,
   parameter int HOME_FLOOR = 1
) (
   input  logic [FLOOR_W-1:0] floor_i,
   input  logic [FLOOR_W-1:0] target_i,
   output logic               tgt_above_o,
   output logic               tgt_below_o,
   output logic               above_home_o
);
   localparam logic [FLOOR_W-1:0] HOME_V = FLOOR_W'(HOME_FLOOR);

   always_comb begin
      tgt_above_o  = target_i > floor_i;
      tgt_below_o  = target_i < floor_i;
      above_home_o = floor_i > HOME_V;
   end
endmodule

// File: rtl/elev_dwell_timer.sv
module elev_dwell_timer #(
   parameter int DWELL_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int CNT_W = $clog2(DWELL_TICKS + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_TICKS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i)
         cnt_q <= '0;
      else if (tick_i && (cnt_q != LIMIT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == LIMIT);

   // R4: count never passes the limit
   a_r4_dwell_saturates : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   // R4: count restarts when the dwell is not running
   a_r4_dwell_clears : assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/elev_mode_fsm.sv
module elev_mode_fsm
   import elev_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fire_i,
   input  logic     tgt_above_i,
   input  logic     tgt_below_i,
   input  logic     above_home_i,
   input  logic     dwell_done_i,
   output car_cmd_t cmd_o
);
   car_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_REST:      if (tgt_above_i) state_d = ST_ASCEND;
                       else if (tgt_below_i) state_d = ST_DESCND;
         ST_ASCEND:    if (!tgt_above_i) state_d = ST_DWELL;
         ST_DESCND:    if (!tgt_below_i) state_d = ST_DWELL;
         ST_DWELL:     if (dwell_done_i) state_d = ST_REST;
         ST_FIRE_DN:   if (!above_home_i) state_d = ST_FIRE_OPEN;
         ST_FIRE_OPEN: if (!fire_i) state_d = ST_REST;
         default:      state_d = ST_REST;
      endcase
      if (fire_i && !is_fire_state(state_q))
         state_d = ST_FIRE_DN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_REST;
      else        state_q <= state_d;
   end

   always_comb begin
      cmd_o = '0;
      unique case (state_q)
         ST_REST:      cmd_o.open = 1'b1;
         ST_ASCEND:    cmd_o.up   = 1'b1;
         ST_DESCND:    cmd_o.dn   = 1'b1;
         ST_DWELL:     begin cmd_o.open = 1'b1; cmd_o.run = 1'b1; end
         ST_FIRE_DN:   cmd_o.dn   = above_home_i;
         ST_FIRE_OPEN: cmd_o.open = 1'b1;
         default:      cmd_o = '0;
      endcase
   end

   a_r5_door_shut_in_motion : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o.up || cmd_o.dn) |-> !cmd_o.open);

   a_r5_single_direction : assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_o.up && cmd_o.dn));

   a_r6_fire_preempts : assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && !is_fire_state(state_q)) |=> (state_q == ST_FIRE_DN));

   a_r7_fire_descends : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FIRE_DN && above_home_i) |-> (cmd_o.dn && !cmd_o.open));

   a_r8_descent_completes : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_FIRE_DN) |-> is_fire_state(state_q));
endmodule

// File: rtl/elev_unit_ctrl.sv
module elev_unit_ctrl
   import elev_pkg::*;
#(
   parameter int FLOOR_W     = 4,
   parameter int HOME_FLOOR  = 1,
   parameter int DWELL_TICKS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLOOR_W-1:0] floor_i,
   input  logic [FLOOR_W-1:0] target_i,
   input  logic               fire_i,
   input  logic               tick_i,
   output logic               move_up_o,
   output logic               move_dn_o,
   output logic               door_open_o,
   output logic               dwell_run_o
);
   localparam int TOP_FLOOR = (1 << FLOOR_W) - 1;

   if (FLOOR_W < 2 || FLOOR_W > 16) begin : g_bad_width
      $error("elev_unit_ctrl: FLOOR_W out of range");
   end
   if (HOME_FLOOR < 0 || HOME_FLOOR > TOP_FLOOR) begin : g_bad_home
      $error("elev_unit_ctrl: HOME_FLOOR not representable");
   end
   if (DWELL_TICKS < 1) begin : g_bad_dwell
      $error("elev_unit_ctrl: DWELL_TICKS must be positive");
   end

   logic     tgt_above, tgt_below, above_home, dwell_done;
   car_cmd_t cmd;

   elev_floor_cmp #(.FLOOR_W(FLOOR_W), .HOME_FLOOR(HOME_FLOOR)) u_cmp (
      .floor_i      (floor_i),
      .target_i     (target_i),
      .tgt_above_o  (tgt_above),
      .tgt_below_o  (tgt_below),
      .above_home_o (above_home)
   );

   elev_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (cmd.run),
      .tick_i (tick_i),
      .done_o (dwell_done)
   );

   elev_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire_i       (fire_i),
      .tgt_above_i  (tgt_above),
      .tgt_below_i  (tgt_below),
      .above_home_i (above_home),
      .dwell_done_i (dwell_done),
      .cmd_o        (cmd)
   );

   assign move_up_o   = cmd.up;
   assign move_dn_o   = cmd.dn;
   assign door_open_o = cmd.open;
   assign dwell_run_o = cmd.run;
endmodule

// File: tb/test_elev_unit_ctrl.sv
module test_elev_unit_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] floor_i = 4'd2;
   logic [3:0] target_i = 4'd2;
   logic       fire_i = 1'b0;
   logic       tick_i = 1'b0;
   logic       move_up_o, move_dn_o, door_open_o, dwell_run_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   elev_unit_ctrl i_elev_unit_ctrl (
      .clk(clk), .rst_n(rst_n), .floor_i(floor_i), .target_i(target_i),
      .fire_i(fire_i), .tick_i(tick_i), .move_up_o(move_up_o),
      .move_dn_o(move_dn_o), .door_open_o(door_open_o), .dwell_run_o(dwell_run_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // expected {up, dn, open, run}
   task automatic expect_cmd(string tag, logic [3:0] exp);
      logic [3:0] act;
      act = {move_up_o, move_dn_o, door_open_o, dwell_run_o};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   localparam logic [3:0] REST = 4'b0010, UP = 4'b1000, DN = 4'b0100,
                          DWELL = 4'b0011, SHUT = 4'b0000;

   task automatic do_reset();
      rst_n = 1'b0; fire_i = 0; tick_i = 0; floor_i = 4'd2; target_i = 4'd2;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic ticks(int n);
      for (int k = 0; k < n; k++) begin
         tick_i = 1'b1; step(); tick_i = 1'b0; step();
      end
   endtask

   task automatic t_reset();
      do_reset();
      expect_cmd("R1 reset rest", REST);
      step(); step();
      expect_cmd("R2 equal target stays resting", REST);
   endtask

   task automatic t_up_trip();
      do_reset();
      target_i = 4'd6; step();
      expect_cmd("R2 target above -> up", UP);
      tick_i = 1; step(); tick_i = 0; floor_i = 4'd4; step(); ticks(4);
      expect_cmd("R3 still climbing", UP);
      floor_i = 4'd6; step();
      expect_cmd("R3 arrival -> dwell", DWELL);
      ticks(9);
      expect_cmd("R4 ticks before dwell ignored, 9 ticks still dwell", DWELL);
      tick_i = 1; step(); tick_i = 0;
      expect_cmd("R4 tenth tick sampled, still dwell", DWELL);
      step();
      expect_cmd("R4 dwell expired -> rest", REST);
   endtask

   task automatic t_down_trip();
      do_reset();
      floor_i = 4'd9; target_i = 4'd9; step();
      target_i = 4'd3; step();
      expect_cmd("R2 target below -> down", DN);
      floor_i = 4'd5; step();
      expect_cmd("R3 still descending", DN);
      floor_i = 4'd3; step();
      expect_cmd("R3 descent arrival -> dwell", DWELL);
      ticks(10); step();
      expect_cmd("R4 dwell after descent -> rest", REST);
   endtask

   task automatic t_fire_vs_dwell();
      do_reset();
      target_i = 4'd4; step(); floor_i = 4'd4; step();
      expect_cmd("R3 dwell reached", DWELL);
      ticks(9);
      tick_i = 1; step(); tick_i = 0;
      fire_i = 1; step();
      expect_cmd("R6 fire beats dwell expiry", DN);
      fire_i = 0; step(); step();
      expect_cmd("R8 clearing fire in descent keeps descending", DN);
      floor_i = 4'd1; #1;
      expect_cmd("R7 at home descent stops", SHUT);
      step();
      expect_cmd("R7 door open at home", REST);
      target_i = 4'd5; step();
      expect_cmd("R8 exit goes to rest first", REST);
      step();
      expect_cmd("R8 normal dispatch resumes", UP);
   endtask

   task automatic t_fire_vs_arrival();
      do_reset();
      target_i = 4'd7; step();
      expect_cmd("R2 climbing", UP);
      floor_i = 4'd7; fire_i = 1; step();
      expect_cmd("R6 fire beats arrival", DN);
      expect_cmd("R5 no open while moving", DN);
      floor_i = 4'd0; step();
      expect_cmd("R7 floor below home -> door open", REST);
      target_i = 4'd9; step(); step(); step();
      expect_cmd("R8 fire held keeps door open at home", REST);
      fire_i = 0; step();
      expect_cmd("R8 fire cleared -> rest", REST);
      step();
      expect_cmd("R2 dispatch after fire", UP);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_up_trip();
            t_down_trip();
            t_fire_vs_dwell();
            t_fire_vs_arrival();
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule